// File: doc/BRIEF.md
# Shadowed Four-Channel PWM Generator

This block produces a pulse-width-modulated waveform on each of several channels. Each channel counts input clock cycles over a programmable period. Its output is low for a programmable number of leading cycles in that period and high for the rest. Software programs the block through a simple 32-bit register bus. Writes take effect on the clock edge, and reads return data in the same cycle from a combinational decode.

Each channel's period and low-count registers are copied into private working registers when the channel is started. After that, software can rewrite the registers without disturbing the running waveform. To commit new values, software raises and then lowers the channel's update bit. The block then swaps the new values in at the next period boundary, so no period is ever cut short. The pin stays low while a channel is stopped. A polarity bit inverts the running waveform, and a separate output-enable bit per channel is driven straight to a pin.

Top module: `pwm_shadow_bank`

## Requirements
- R1: After reset, every period register reads 2 and every low-count register reads 1. The polarity, start, done, update and output-enable registers read 0, and all pins and output enables are 0.
- R2: Channel n has its low-count register at byte address 8n and its period register at 8n+4. Both registers store the low 30 bits of the written data and read back with the upper bits zero. Bit n of each shared register belongs to channel n: polarity at 0x40, start at 0x44, done at 0x48 (read-only), update at 0x4C, output enable at 0xD0.
- R3: When a channel's start bit is written from 0 to 1, the working period P and low-count L are loaded and the counter restarts at 0. With polarity 0, the pin is low for the first L cycles of every P-cycle period and high for the remaining cycles. Register writes made while the channel runs do not change the pin.
- R4: A low-count of 0 gives a constant high pin while the channel is running with polarity 0.
- R5: A low-count greater than or equal to the period gives a constant low pin while the channel is running with polarity 0.
- R6: While a channel's start bit is 0, its pin is 0, whatever its polarity bit holds.
- R7: While a channel runs with its polarity bit set to 1, its pin is the exact inverse of the polarity-0 waveform.
- R8: A write that moves a running channel's update bit from 1 to 0 commits its registers. At the end of the current period, the register values present then become the working values, and the next period uses them.
- R9: A channel's done bit is 1 for exactly the one cycle that follows the end of each of its periods, and it can be read at address 0x48.
- R10: The output-enable pins follow the output-enable register bits from the cycle after the write.
- R11: A period register value below 2 is loaded as a working period of 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, also the PWM count clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Write strobe, acted on at the rising clock edge |
| busAddr | input | 8 | Byte address for reads and writes |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, same cycle |
| pwmOut | output | 4 | PWM pins, one per channel |
| pwmOe | output | 4 | Output-enable pins, one per channel |

## Verification
The bench builds the block with its default parameters: four channels and a 30-bit count. At these settings, short periods of two to eight cycles let every channel wrap many times within each phase. Each channel gets its own case at the same time: a normal duty, a constant-high duty, a constant-low duty and an inverted duty. These settings also make it easy to reach the interaction between commits and period boundaries, stopping an inverted channel, and clamping a too-small period. The 30-bit width of the period field is exercised only through register read-back.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;
  // Shared register byte offsets (bit n of each belongs to channel n)
  localparam int unsigned OFS_POL   = 32'h40;
  localparam int unsigned OFS_START = 32'h44;
  localparam int unsigned OFS_DONE  = 32'h48;
  localparam int unsigned OFS_UPD   = 32'h4C;
  localparam int unsigned OFS_OE    = 32'hD0;
  localparam int unsigned PER_RESET = 2;
  localparam int unsigned LOW_RESET = 1;

  // Per-channel strobes from control to datapath
  typedef struct packed {
    logic load;    // start bit rising this edge
    logic commit;  // update bit falling this edge
    logic run;     // start bit level
    logic invert;  // polarity bit level
  } chanCtl_t;
endpackage

// File: rtl/pwm_shadow_ctrl.sv
module pwm_shadow_ctrl
  import pwm_shadow_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 30,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             busWr,
  input  logic [ADDR_W-1:0]                busAddr,
  input  logic [DATA_W-1:0]                busWdata,
  output logic [DATA_W-1:0]                busRdata,
  input  logic [NUM_CH-1:0]                doneBits,
  output logic [NUM_CH-1:0][CNT_W-1:0]     perRegs,
  output logic [NUM_CH-1:0][CNT_W-1:0]     lowRegs,
  output chanCtl_t [NUM_CH-1:0]            chanCtl,
  output logic [NUM_CH-1:0]                oeBits
);
  localparam logic [ADDR_W-1:0] A_POL   = ADDR_W'(OFS_POL);
  localparam logic [ADDR_W-1:0] A_START = ADDR_W'(OFS_START);
  localparam logic [ADDR_W-1:0] A_DONE  = ADDR_W'(OFS_DONE);
  localparam logic [ADDR_W-1:0] A_UPD   = ADDR_W'(OFS_UPD);
  localparam logic [ADDR_W-1:0] A_OE    = ADDR_W'(OFS_OE);

  logic [NUM_CH-1:0] polQ, startQ, updQ, oeQ;
  logic [NUM_CH-1:0] wdBits;
  logic wrStart, wrUpd;

  assign wdBits  = busWdata[NUM_CH-1:0];
  assign wrStart = busWr && (busAddr == A_START);
  assign wrUpd   = busWr && (busAddr == A_UPD);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      polQ   <= '0;
      startQ <= '0;
      updQ   <= '0;
      oeQ    <= '0;
    end else if (busWr) begin
      if (busAddr == A_POL)   polQ   <= wdBits;
      if (busAddr == A_START) startQ <= wdBits;
      if (busAddr == A_UPD)   updQ   <= wdBits;
      if (busAddr == A_OE)    oeQ    <= wdBits;
    end
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : gChanRegs
    localparam logic [ADDR_W-1:0] A_LOW = ADDR_W'(8 * n);
    localparam logic [ADDR_W-1:0] A_PER = ADDR_W'(8 * n + 4);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        perRegs[n] <= CNT_W'(PER_RESET);
        lowRegs[n] <= CNT_W'(LOW_RESET);
      end else if (busWr) begin
        if (busAddr == A_PER) perRegs[n] <= busWdata[CNT_W-1:0];
        if (busAddr == A_LOW) lowRegs[n] <= busWdata[CNT_W-1:0];
      end
    end

    assign chanCtl[n].load   = wrStart && wdBits[n] && !startQ[n];
    assign chanCtl[n].commit = wrUpd && !wdBits[n] && updQ[n];
    assign chanCtl[n].run    = startQ[n];
    assign chanCtl[n].invert = polQ[n];
  end

  always_comb begin
    busRdata = '0;
    for (int n = 0; n < NUM_CH; n++) begin
      if (busAddr == ADDR_W'(8 * n))     busRdata = DATA_W'(lowRegs[n]);
      if (busAddr == ADDR_W'(8 * n + 4)) busRdata = DATA_W'(perRegs[n]);
    end
    if (busAddr == A_POL)   busRdata = DATA_W'(polQ);
    if (busAddr == A_START) busRdata = DATA_W'(startQ);
    if (busAddr == A_DONE)  busRdata = DATA_W'(doneBits);
    if (busAddr == A_UPD)   busRdata = DATA_W'(updQ);
    if (busAddr == A_OE)    busRdata = DATA_W'(oeQ);
  end

  assign oeBits = oeQ;
endmodule

// File: rtl/pwm_shadow_datapath.sv
module pwm_shadow_datapath
  import pwm_shadow_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 30
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_CH-1:0][CNT_W-1:0] perRegs,
  input  logic [NUM_CH-1:0][CNT_W-1:0] lowRegs,
  input  chanCtl_t [NUM_CH-1:0]        chanCtl,
  output logic [NUM_CH-1:0]            pwmOut,
  output logic [NUM_CH-1:0]            doneBits
);
  localparam logic [CNT_W-1:0] MIN_PER = CNT_W'(PER_RESET);

  for (genvar n = 0; n < NUM_CH; n++) begin : gChan
    logic [CNT_W-1:0] cntQ, wPerQ, wLowQ, perFixed;
    logic pendQ, doneQ, atWrap, rawHigh;

    assign perFixed = (perRegs[n] < MIN_PER) ? MIN_PER : perRegs[n];
    assign atWrap   = (cntQ == wPerQ - CNT_W'(1));
    assign rawHigh  = (cntQ >= wLowQ);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cntQ  <= '0;
        wPerQ <= MIN_PER;
        wLowQ <= CNT_W'(LOW_RESET);
        pendQ <= 1'b0;
        doneQ <= 1'b0;
      end else begin
        doneQ <= 1'b0;
        if (chanCtl[n].load) begin
          cntQ  <= '0;
          wPerQ <= perFixed;
          wLowQ <= lowRegs[n];
          pendQ <= 1'b0;
        end else if (!chanCtl[n].run) begin
          cntQ  <= '0;
          pendQ <= 1'b0;
        end else if (atWrap) begin
          cntQ  <= '0;
          doneQ <= 1'b1;
          if (pendQ) begin
            wPerQ <= perFixed;
            wLowQ <= lowRegs[n];
          end
          pendQ <= chanCtl[n].commit;
        end else begin
          cntQ  <= cntQ + CNT_W'(1);
          pendQ <= pendQ | chanCtl[n].commit;
        end
      end
    end

    assign pwmOut[n]   = chanCtl[n].run & (rawHigh ^ chanCtl[n].invert);
    assign doneBits[n] = doneQ;
  end
endmodule

// File: rtl/pwm_shadow_bank.sv
module pwm_shadow_bank
  import pwm_shadow_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 30,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [NUM_CH-1:0] pwmOut,
  output logic [NUM_CH-1:0] pwmOe
);
  logic [NUM_CH-1:0][CNT_W-1:0] perRegs, lowRegs;
  chanCtl_t [NUM_CH-1:0]        chanCtl;
  logic [NUM_CH-1:0]            doneBits;

  pwm_shadow_ctrl #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .doneBits(doneBits),
    .perRegs(perRegs), .lowRegs(lowRegs), .chanCtl(chanCtl), .oeBits(pwmOe)
  );

  pwm_shadow_datapath #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W)
  ) uData (
    .clk(clk), .rstN(rstN), .perRegs(perRegs), .lowRegs(lowRegs),
    .chanCtl(chanCtl), .pwmOut(pwmOut), .doneBits(doneBits)
  );
endmodule

// File: rtl/pwm_shadow_bank_chk.sv
module pwm_shadow_bank_chk
  import pwm_shadow_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  busWr,
  input logic [ADDR_W-1:0]     busAddr,
  input logic [DATA_W-1:0]     busWdata,
  input logic [NUM_CH-1:0]     pwmOut,
  input logic [NUM_CH-1:0]     pwmOe,
  input chanCtl_t [NUM_CH-1:0] chanCtl,
  input logic [NUM_CH-1:0]     doneBits
);
  AST_OE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_W'(OFS_OE)) |=> (pwmOe == $past(busWdata[NUM_CH-1:0]))); // R10

  for (genvar n = 0; n < NUM_CH; n++) begin : gChk
    AST_IDLE_PIN_LOW: assert property (@(posedge clk) disable iff (!rstN)
      !chanCtl[n].run |-> !pwmOut[n]); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
      doneBits[n] |=> !doneBits[n]); // R9
    AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rstN)
      doneBits[n] |-> $past(chanCtl[n].run)); // R9
  end
endmodule

bind pwm_shadow_bank pwm_shadow_bank_chk #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) uChk (
  .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
  .busWdata(busWdata), .pwmOut(pwmOut), .pwmOe(pwmOe),
  .chanCtl(chanCtl), .doneBits(doneBits)
);

// File: tb/pwm_shadow_bank_test.sv
module pwm_shadow_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busAddr = 8'h48;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [3:0]  pwmOut, pwmOe;

  int checks = 0;
  int errors = 0;
  string phaseTag = "R1";

  pwm_shadow_bank uut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .pwmOut(pwmOut), .pwmOe(pwmOe)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Reference model state
  logic [29:0] mPer[NCH], mLow[NCH], wPer[NCH], wLow[NCH], cnt[NCH];
  logic [3:0]  mPol, mStart, mUpd, mOe, mDone;
  logic [3:0]  pend;

  function automatic logic [29:0] fixPer(logic [29:0] p);
    return (p < 2) ? 30'd2 : p;
  endfunction

  task automatic modelReset();
    for (int c = 0; c < NCH; c++) begin
      mPer[c] = 2; mLow[c] = 1; wPer[c] = 2; wLow[c] = 1; cnt[c] = 0;
    end
    mPol = 0; mStart = 0; mUpd = 0; mOe = 0; mDone = 0; pend = 0;
  endtask

  initial modelReset();

  always @(posedge clk) begin
    if (!rstN) modelReset();
    else begin
      for (int c = 0; c < NCH; c++) begin
        bit ld, cm;
        ld = busWr && busAddr == 8'h44 && busWdata[c] && !mStart[c];
        cm = busWr && busAddr == 8'h4C && !busWdata[c] && mUpd[c];
        mDone[c] = 1'b0;
        if (ld) begin
          cnt[c] = 0; wPer[c] = fixPer(mPer[c]); wLow[c] = mLow[c]; pend[c] = 0;
        end else if (!mStart[c]) begin
          cnt[c] = 0; pend[c] = 0;
        end else if (cnt[c] == wPer[c] - 1) begin
          cnt[c] = 0; mDone[c] = 1'b1;
          if (pend[c]) begin wPer[c] = fixPer(mPer[c]); wLow[c] = mLow[c]; end
          pend[c] = cm;
        end else begin
          cnt[c] = cnt[c] + 1; pend[c] = pend[c] | cm;
        end
      end
      if (busWr) begin
        if (busAddr < 8'h20) begin
          if (busAddr[2]) mPer[busAddr[4:3]] = busWdata[29:0];
          else            mLow[busAddr[4:3]] = busWdata[29:0];
        end
        if (busAddr == 8'h40) mPol   = busWdata[3:0];
        if (busAddr == 8'h44) mStart = busWdata[3:0];
        if (busAddr == 8'h4C) mUpd   = busWdata[3:0];
        if (busAddr == 8'hD0) mOe    = busWdata[3:0];
      end
    end
  end

  function automatic logic expPin(int c);
    if (!mStart[c]) return 1'b0;
    return (cnt[c] >= wLow[c]) ^ mPol[c];
  endfunction

  function automatic string pinTag(int c);
    if (!mStart[c]) return "R6";
    if (mPol[c]) return "R7";
    if (wLow[c] == 0) return "R4";
    if (wLow[c] >= wPer[c]) return "R5";
    return "R3";
  endfunction

  task automatic check(bit ok, string tag, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
    end
  endtask

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      for (int c = 0; c < NCH; c++)
        check(pwmOut[c] === expPin(c), $sformatf("%s/%s", phaseTag, pinTag(c)),
              $sformatf("pin ch%0d", c), 32'(pwmOut[c]), 32'(expPin(c)));
      check(pwmOe === mOe, "R10", "output enable", 32'(pwmOe), 32'(mOe));
      if (!busWr && busAddr == 8'h48)
        check(busRdata === 32'(mDone), "R9", "done register", busRdata, 32'(mDone));
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #2;
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); #2;
    busWr = 1'b0; busAddr = 8'h48;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    @(posedge clk); #2;
    busAddr = a;
    #1;
    check(busRdata === exp, tag, $sformatf("read @%h", a), busRdata, exp);
    busAddr = 8'h48;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    #1;
    check(pwmOut === 4'b0, "R1", "pins in reset", 32'(pwmOut), 0);
    check(pwmOe === 4'b0, "R1", "oe in reset", 32'(pwmOe), 0);
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    // R1: reset values read back
    for (int c = 0; c < NCH; c++) begin
      rd(8'(8 * c), 32'd1, "R1");
      rd(8'(8 * c + 4), 32'd2, "R1");
    end
    rd(8'h40, 0, "R1"); rd(8'h44, 0, "R1"); rd(8'h48, 0, "R1");
    rd(8'h4C, 0, "R1"); rd(8'hD0, 0, "R1");

    // R10 / R2: output-enable bits
    phaseTag = "R10";
    wr(8'hD0, 32'h5);
    rd(8'hD0, 32'h5, "R2");

    // R3, R4, R5, R7: four channels with distinct settings
    phaseTag = "R3";
    wr(8'h00, 2); wr(8'h04, 5);
    wr(8'h08, 0); wr(8'h0C, 4);
    wr(8'h10, 3); wr(8'h14, 3);
    wr(8'h18, 1); wr(8'h1C, 6);
    wr(8'h40, 32'h8);
    wr(8'h44, 32'hF);
    idle(30);

    // R3: register writes while running leave the pin alone
    wr(8'h04, 8); wr(8'h00, 5);
    idle(15);

    // R8: commit applied at the next period boundary
    phaseTag = "R8";
    wr(8'h4C, 1); wr(8'h4C, 0);
    idle(30);

    // R6: stopping the inverted channel idles it low
    phaseTag = "R6";
    wr(8'h44, 32'h7);
    idle(10);

    // R11: period below the minimum is clamped to 2
    phaseTag = "R11";
    wr(8'h44, 32'h3);
    wr(8'h14, 1); wr(8'h10, 1);
    wr(8'h44, 32'h7);
    idle(12);

    // R2: field width and shared register read-back
    phaseTag = "R2";
    wr(8'h1C, 32'hFFFF_FFFF);
    rd(8'h1C, 32'h3FFF_FFFF, "R2");
    rd(8'h40, 32'h8, "R2");
    rd(8'h44, 32'h7, "R2");
    idle(4);
    finishRun();
  end
endmodule